// File: doc/BRIEF.md
# GPIO Pad Bank with Interrupt Status

This block controls a bank of general-purpose pads (64 by default) through a plain word-wide read/write bus. Each pad owns a 16-byte register group. The group holds a configuration word, a spare configuration word and a value word. Software uses these words to choose the pad's function mux setting, its pull direction and strength, open-drain behaviour, its input and output enables and its output level.

Each pad input passes through a synchronizer. The synchronized value feeds an event detector. A trigger selection in the configuration word makes the detector watch for a rising edge, a falling edge, both edges, a high level or a low level. Detected events set sticky bits in a shared status region that holds one bit per pad, packed 32 pads to a word. Software clears a status bit by writing a one to it. A single interrupt output is asserted while any status bit is set.

Bus reads return data one clock after the request is sampled. Writes take effect at the clock edge that samples them.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every configuration word reads 0 and every value word reads 0x6 (both enables off, level 0). Every status word reads 0, `irq_o` is low and no pad output enable is asserted.
- R2: The configuration word of pad p sits at byte address p*16. Its fields are: function mux in bits [2:0], pull select in bits [8:7] (01 pull up, 10 pull down), pull strength in bits [10:9], level-mode select in bit 24, rising/high select in bit 25, falling/low select in bit 26 and open-drain enable in bit 31. All other bits read 0. The word at p*16+4 stores all 32 bits. The mux, pull and strength fields appear on the matching pad outputs.
- R3: The value word sits at p*16+8. Bit 1 is an active-low output enable and bit 0 is the output level, driven on `pad_out_o`. With open drain enabled, the pad is driven only while the level is 0 (it is driven low), and it is released while the level is 1.
- R4: Bit 2 of the value word is an active-low input enable. While the input is enabled, a read of bit 0 returns the synchronized pad input. Otherwise bit 0 returns the stored output level.
- R5: With bit 24 clear, bit 25 alone sets the pad's status bit on rising edges only, bit 26 alone on falling edges only, and both bits together on either edge. The status bit is visible on the third rising clock edge after the input change is first sampled.
- R6: With bit 24 set, bit 25 selects active-high level and bit 26 selects active-low level. The status bit is set again on every cycle while the level holds, so a clear does not stick until the level goes away.
- R7: With bits 24, 25 and 26 all clear, input activity never sets the pad's status bit.
- R8: The status word for pads 32k..32k+31 sits at 0x800+4k, and pad p uses bit p mod 32. Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. A write to one status word does not affect another.
- R9: When a pad event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R10: `irq_o` is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pad_in_i | input | NUM_PADS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PADS | Pad output level |
| pad_oe_o | output | NUM_PADS | Pad output driver enable |
| pad_pu_o | output | NUM_PADS | Pull-up select |
| pad_pd_o | output | NUM_PADS | Pull-down select |
| pad_pull_str_o | output | 2*NUM_PADS | Pull strength code, 2 bits per pad |
| pad_mux_o | output | 3*NUM_PADS | Function mux code, 3 bits per pad |
| irq_o | output | 1 | Combined interrupt |

## Verification
The collision that matters is a fresh pad event and a software write-one-to-clear landing on the same status bit in the same clock. The bench first sets a pad's status bit through a both-edge trigger. It then drops the pad input and places the clear write exactly two cycles later, so the write is sampled at the edge where the falling-edge event is latched. The bit must still read as set and `irq_o` must stay high. A second clear with no event must then empty the bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W = 32;

  localparam int BIT_OD   = 31;
  localparam int BIT_FALL = 26;
  localparam int BIT_RISE = 25;
  localparam int BIT_LVL  = 24;

  typedef enum logic [1:0] {
    REG_CONF0 = 2'd0,
    REG_CONF1 = 2'd1,
    REG_VALUE = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       od;
    logic       trig_fall;
    logic       trig_rise;
    logic       trig_lvl;
    logic [1:0] pull_str;
    logic [1:0] pull_sel;
    logic [2:0] mux;
  } pad_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(input pad_cfg_t c);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[BIT_OD]   = c.od;
    w[BIT_FALL] = c.trig_fall;
    w[BIT_RISE] = c.trig_rise;
    w[BIT_LVL]  = c.trig_lvl;
    w[10:9]     = c.pull_str;
    w[8:7]      = c.pull_sel;
    w[2:0]      = c.mux;
    return w;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          rsel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              in_i,
  output logic [WORD_W-1:0] conf0_o,
  output logic [WORD_W-1:0] conf1_o,
  output logic [WORD_W-1:0] val_o,
  output logic              evt_o,
  output logic              out_o,
  output logic              oe_o,
  output logic              pu_o,
  output logic              pd_o,
  output logic [1:0]        pull_str_o,
  output logic [2:0]        mux_o
);

  pad_cfg_t          cfg_q;
  logic [WORD_W-1:0] conf1_q;
  logic              in_en_n_q, out_en_n_q, level_q;
  logic              prev_q;
  logic              rise, fall, lvl_hit, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      conf1_q    <= '0;
      in_en_n_q  <= 1'b1;
      out_en_n_q <= 1'b1;
      level_q    <= 1'b0;
    end else if (wr_i) begin
      case (rsel_i)
        REG_CONF0: begin
          cfg_q.od        <= wdata_i[BIT_OD];
          cfg_q.trig_fall <= wdata_i[BIT_FALL];
          cfg_q.trig_rise <= wdata_i[BIT_RISE];
          cfg_q.trig_lvl  <= wdata_i[BIT_LVL];
          cfg_q.pull_str  <= wdata_i[10:9];
          cfg_q.pull_sel  <= wdata_i[8:7];
          cfg_q.mux       <= wdata_i[2:0];
        end
        REG_CONF1: conf1_q <= wdata_i;
        REG_VALUE: begin
          in_en_n_q  <= wdata_i[2];
          out_en_n_q <= wdata_i[1];
          level_q    <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= in_i;
  end

  assign rise     = in_i & ~prev_q;
  assign fall     = ~in_i & prev_q;
  // level mode reuses the edge selects as polarity selects
  assign lvl_hit  = (cfg_q.trig_rise & in_i) | (cfg_q.trig_fall & ~in_i);
  assign edge_hit = (cfg_q.trig_rise & rise) | (cfg_q.trig_fall & fall);
  assign evt_o    = cfg_q.trig_lvl ? lvl_hit : edge_hit;

  assign conf0_o    = cfg_to_word(cfg_q);
  assign conf1_o    = conf1_q;
  assign val_o      = {29'd0, in_en_n_q, out_en_n_q, in_en_n_q ? level_q : in_i};
  assign out_o      = cfg_q.od ? 1'b0 : level_q;
  assign oe_o       = ~out_en_n_q & ~(cfg_q.od & level_q);
  assign pu_o       = (cfg_q.pull_sel == 2'b01);
  assign pd_o       = (cfg_q.pull_sel == 2'b10);
  assign pull_str_o = cfg_q.pull_str;
  assign mux_o      = cfg_q.mux;

  // R7
  no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf0_o[BIT_FALL:BIT_LVL] == 3'b000) |-> !evt_o);

  // R5
  rise_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf0_o[BIT_FALL:BIT_LVL] == 3'b010 && $rose(in_i)) |-> evt_o);

  // R3
  od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf0_o[BIT_OD] && val_o[0] && in_en_n_q) |-> !oe_o);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PADS    = 64,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  input  logic [NUM_PADS-1:0]   pad_in_i,
  output logic [NUM_PADS-1:0]   pad_out_o,
  output logic [NUM_PADS-1:0]   pad_oe_o,
  output logic [NUM_PADS-1:0]   pad_pu_o,
  output logic [NUM_PADS-1:0]   pad_pd_o,
  output logic [2*NUM_PADS-1:0] pad_pull_str_o,
  output logic [3*NUM_PADS-1:0] pad_mux_o,
  output logic                  irq_o
);

  localparam int PAD_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int NUM_WORDS = (NUM_PADS + WORD_W - 1) / WORD_W;
  localparam int SW_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int STAT_BIT  = ADDR_W - 1;
  localparam int PIDX_W    = STAT_BIT - 4;
  localparam int SIDX_W    = STAT_BIT - 2;

  // ---------------- address decode ----------------
  logic              aligned, stat_sel, pad_hit, stat_hit;
  logic [PIDX_W-1:0] pidx;
  logic [SIDX_W-1:0] sidx;
  logic [PAD_W-1:0]  pidx_s;
  logic [SW_W-1:0]   sidx_s;
  reg_sel_e          rsel;

  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign stat_sel = bus_addr_i[STAT_BIT];
  assign pidx     = bus_addr_i[STAT_BIT-1:4];
  assign sidx     = bus_addr_i[STAT_BIT-1:2];
  assign rsel     = reg_sel_e'(bus_addr_i[3:2]);
  assign pad_hit  = bus_req_i && aligned && !stat_sel && (int'(pidx) < NUM_PADS);
  assign stat_hit = bus_req_i && aligned &&  stat_sel && (int'(sidx) < NUM_WORDS);
  assign pidx_s   = pidx[PAD_W-1:0];
  assign sidx_s   = sidx[SW_W-1:0];

  // ---------------- synchronizer ----------------
  logic [NUM_PADS-1:0] in_sync;

  gpio_bank_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (in_sync)
  );

  // ---------------- pad register groups ----------------
  logic [WORD_W-1:0]   conf0_rd [NUM_PADS];
  logic [WORD_W-1:0]   conf1_rd [NUM_PADS];
  logic [WORD_W-1:0]   val_rd   [NUM_PADS];
  logic [NUM_PADS-1:0] evt;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic pad_wr;
    assign pad_wr = pad_hit && bus_we_i && (pidx == PIDX_W'(p));

    gpio_bank_pad u_pad (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (pad_wr),
      .rsel_i     (rsel),
      .wdata_i    (bus_wdata_i),
      .in_i       (in_sync[p]),
      .conf0_o    (conf0_rd[p]),
      .conf1_o    (conf1_rd[p]),
      .val_o      (val_rd[p]),
      .evt_o      (evt[p]),
      .out_o      (pad_out_o[p]),
      .oe_o       (pad_oe_o[p]),
      .pu_o       (pad_pu_o[p]),
      .pd_o       (pad_pd_o[p]),
      .pull_str_o (pad_pull_str_o[2*p +: 2]),
      .mux_o      (pad_mux_o[3*p +: 3])
    );
  end

  // ---------------- interrupt status ----------------
  logic [NUM_PADS-1:0] stat_q, clr;
  logic [WORD_W-1:0]   stat_word [NUM_WORDS];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_clr
    assign clr[p] = stat_hit && bus_we_i && (sidx_s == SW_W'(p / WORD_W))
                    && bus_wdata_i[p % WORD_W];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (w * WORD_W + b < NUM_PADS) begin : g_live
        assign stat_word[w][b] = stat_q[w*WORD_W + b];
      end else begin : g_pad0
        assign stat_word[w][b] = 1'b0;
      end
    end
  end

  // a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | evt;
  end

  assign irq_o = |stat_q;

  // ---------------- read path ----------------
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (pad_hit) begin
      case (rsel)
        REG_CONF0: rd_next = conf0_rd[pidx_s];
        REG_CONF1: rd_next = conf1_rd[pidx_s];
        REG_VALUE: rd_next = val_rd[pidx_s];
        default:   rd_next = '0;
      endcase
    end else if (stat_hit) begin
      rd_next = stat_word[sidx_s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     bus_rdata_o <= '0;
    else if (bus_req_i && !bus_we_i) bus_rdata_o <= rd_next;
  end

  // R9
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R8
  stat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|evt));

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  localparam int N = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [N-1:0]    pad_in = '0;
  logic [N-1:0]    pad_out, pad_oe, pad_pu, pad_pd;
  logic [2*N-1:0]  pad_str;
  logic [3*N-1:0]  pad_mux;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bus_req_i      (req),
    .bus_we_i       (we),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .pad_in_i       (pad_in),
    .pad_out_o      (pad_out),
    .pad_oe_o       (pad_oe),
    .pad_pu_o       (pad_pu),
    .pad_pd_o       (pad_pd),
    .pad_pull_str_o (pad_str),
    .pad_mux_o      (pad_mux),
    .irq_o          (irq)
  );

  function automatic logic [11:0] padr(input int p, input int r);
    return 12'(p * 16 + r * 4);
  endfunction

  function automatic logic [11:0] sadr(input int k);
    return 12'(12'h800 + 4 * k);
  endfunction

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_s, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_pad(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(padr(0, 0), d);  chk("R1 conf0 pad0", d, 32'h0);
    rd(padr(5, 2), d);  chk("R1 value pad5", d, 32'h6);
    rd(sadr(0), d);     chk("R1 status w0", d, 32'h0);
    rd(sadr(1), d);     chk("R1 status w1", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 oe", 32'(|pad_oe), 32'h0);
  endtask

  task automatic t_conf();
    logic [31:0] d;
    wr(padr(3, 0), 32'hFFFF_FFFF);
    rd(padr(3, 0), d);  chk("R2 conf0 mask", d, 32'h8700_0787);
    chk("R2 mux out", 32'(pad_mux[9 +: 3]), 32'h7);
    wr(padr(3, 0), 32'h0000_0481);
    rd(padr(3, 0), d);  chk("R2 conf0 fields", d, 32'h0000_0481);
    chk("R2 pull up", 32'({pad_pu[3], pad_pd[3]}), 32'h2);
    chk("R2 strength", 32'(pad_str[6 +: 2]), 32'h2);
    chk("R2 mux 1", 32'(pad_mux[9 +: 3]), 32'h1);
    wr(padr(3, 1), 32'hDEAD_BEEF);
    rd(padr(3, 1), d);  chk("R2 conf1", d, 32'hDEAD_BEEF);
    wr(padr(3, 0), 32'h0000_0100);
    chk("R2 pull down", 32'({pad_pu[3], pad_pd[3]}), 32'h1);
    wr(sadr(0), 32'h0000_0008);
    rd(sadr(0), d);     chk("R8 clear after cfg", d, 32'h0);
    chk("R10 irq idle", 32'(irq), 32'h0);
  endtask

  task automatic t_output();
    wr(padr(7, 2), 32'h5);
    chk("R3 oe on", 32'(pad_oe[7]), 32'h1);
    chk("R3 level hi", 32'(pad_out[7]), 32'h1);
    wr(padr(7, 2), 32'h4);
    chk("R3 level lo", 32'(pad_out[7]), 32'h0);
    wr(padr(7, 0), 32'h8000_0000);
    wr(padr(7, 2), 32'h5);
    chk("R3 od release", 32'(pad_oe[7]), 32'h0);
    wr(padr(7, 2), 32'h4);
    chk("R3 od drive", 32'({pad_oe[7], pad_out[7]}), 32'h2);
    wr(padr(7, 2), 32'h6);
    chk("R3 oe off", 32'(pad_oe[7]), 32'h0);
    wr(padr(7, 0), 32'h0);
  endtask

  task automatic t_inread();
    logic [31:0] d;
    wr(padr(9, 2), 32'h2);
    set_pad(9, 1'b1);
    rd(padr(9, 2), d);  chk("R4 input read", d, 32'h3);
    wr(padr(9, 2), 32'h7);
    rd(padr(9, 2), d);  chk("R4 level read", d, 32'h7);
    set_pad(9, 1'b0);
    wr(padr(9, 2), 32'h6);
    rd(padr(9, 2), d);  chk("R4 level lo", d, 32'h6);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(padr(40, 0), 32'h0200_0000);
    set_pad(40, 1'b1);
    rd(sadr(1), d);     chk("R5 rise only: rise", d, 32'h100);
    chk("R10 irq set", 32'(irq), 32'h1);
    wr(sadr(1), 32'h100);
    set_pad(40, 1'b0);
    rd(sadr(1), d);     chk("R5 rise only: fall", d, 32'h0);
    chk("R10 irq clr", 32'(irq), 32'h0);
    wr(padr(40, 0), 32'h0400_0000);
    set_pad(40, 1'b1);
    rd(sadr(1), d);     chk("R5 fall only: rise", d, 32'h0);
    set_pad(40, 1'b0);
    rd(sadr(1), d);     chk("R5 fall only: fall", d, 32'h100);
    wr(sadr(1), 32'h100);
    wr(padr(40, 0), 32'h0600_0000);
    set_pad(40, 1'b1);
    rd(sadr(1), d);     chk("R5 both: rise", d, 32'h100);
    wr(sadr(1), 32'h100);
    set_pad(40, 1'b0);
    rd(sadr(1), d);     chk("R5 both: fall", d, 32'h100);
    wr(sadr(1), 32'h100);
    wr(padr(40, 0), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(padr(63, 0), 32'h0300_0000);
    wait_cyc(3);
    rd(sadr(1), d);     chk("R6 high idle", d, 32'h0);
    set_pad(63, 1'b1);
    wr(sadr(1), 32'h8000_0000);
    rd(sadr(1), d);     chk("R6 high persists", d, 32'h8000_0000);
    set_pad(63, 1'b0);
    wr(sadr(1), 32'h8000_0000);
    rd(sadr(1), d);     chk("R6 high gone", d, 32'h0);
    wr(padr(63, 0), 32'h0500_0000);
    wait_cyc(3);
    wr(sadr(1), 32'h8000_0000);
    rd(sadr(1), d);     chk("R6 low persists", d, 32'h8000_0000);
    set_pad(63, 1'b1);
    wr(sadr(1), 32'h8000_0000);
    rd(sadr(1), d);     chk("R6 low gone", d, 32'h0);
    wr(padr(63, 0), 32'h0);
    set_pad(63, 1'b0);
  endtask

  task automatic t_none();
    logic [31:0] d;
    wr(padr(20, 0), 32'h0000_0787);
    for (int i = 0; i < 3; i++) begin
      set_pad(20, 1'b1);
      set_pad(20, 1'b0);
    end
    rd(sadr(0), d);     chk("R7 no trigger", d, 32'h0);
    chk("R7 irq", 32'(irq), 32'h0);
    wr(padr(20, 0), 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(padr(1, 0), 32'h0600_0000);
    wr(padr(2, 0), 32'h0600_0000);
    @(negedge clk);
    pad_in[1] = 1'b1; pad_in[2] = 1'b1;
    wait_cyc(4);
    rd(sadr(0), d);     chk("R8 two set", d, 32'h6);
    wr(sadr(0), 32'h0);
    rd(sadr(0), d);     chk("R8 zero write", d, 32'h6);
    wr(sadr(0), 32'h2);
    rd(sadr(0), d);     chk("R8 single clear", d, 32'h4);
    wr(sadr(1), 32'h4);
    rd(sadr(0), d);     chk("R8 other word", d, 32'h4);
    chk("R10 irq one left", 32'(irq), 32'h1);
    wr(sadr(0), 32'hFFFF_FFFF);
    rd(sadr(0), d);     chk("R8 clear all", d, 32'h0);
    chk("R10 irq none", 32'(irq), 32'h0);
    wr(padr(1, 0), 32'h0);
    wr(padr(2, 0), 32'h0);
    @(negedge clk);
    pad_in[1] = 1'b0; pad_in[2] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(padr(5, 0), 32'h0600_0000);
    set_pad(5, 1'b1);
    rd(sadr(0), d);     chk("R9 setup", d, 32'h20);
    @(negedge clk);
    pad_in[5] = 1'b0;
    wait_cyc(2);
    req = 1'b1; we = 1'b1; addr = sadr(0); wdata = 32'h20;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(sadr(0), d);     chk("R9 event beats clear", d, 32'h20);
    chk("R9 irq kept", 32'(irq), 32'h1);
    wr(sadr(0), 32'h20);
    rd(sadr(0), d);     chk("R9 later clear", d, 32'h0);
    wr(padr(5, 0), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_conf();
    t_output();
    t_inread();
    t_edge();
    t_level();
    t_none();
    t_w1c();
    t_collide();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule